// File: doc/BRIEF.md
# Per-Pin GPIO Control Cell Bank

This block is a bank of GPIO pin cells. Each pin owns one 32-bit control word on a simple memory-mapped register port. The word chooses the direction, the value driven out, which of three peripheral functions takes over the pad, and how the pin raises interrupts. One 3-bit mode field covers both direction and trigger type. Writing the "input, interrupt off" mode masks a pin. Writing a trigger mode back unmasks it. There is no separate mask bit.

Pad inputs pass through a two-flop synchronizer. Level and edge detection work on the synchronized sample. Each pin's interrupt event is tagged with a 3-bit group number, which routing logic outside the block uses. Pull, drive-strength, Schmitt and input-enable settings are only stored and exported to the analog pad. A lock bit freezes a word until the next reset.

Top module: `gpio_cell_bank`

## Requirements
- R1: After reset every control word reads 0, every padOe, irqEvent and busRdValid is 0, and a pin in mode 0 raises no interrupt.
- R2: Pin n's word is at byte address 4*n. A read returns busRdData with busRdValid one cycle after busRdEn. Bits 12..14, 19, 20 and 24..31 always read 0. An address whose pin index is NUM_PINS or more reads 0 and ignores writes.
- R3: Bit 0 reads back the written value when the mode (bits 3:1) is 1. In every other mode it reads the pad level after the two-flop synchronizer.
- R4: Mode 1 with function select (bits 6:5) equal to 0 drives padOe=1 and padOut=bit 0.
- R5: Function select f in 1..3 routes periphOut and periphOe at index pin*3+f-1 to padOut and padOe. With f=0 and a mode other than 1, padOe is 0.
- R6: Mode 2 holds irqEvent high while the synchronized input is 1. Mode 3 holds it high while the synchronized input is 0.
- R7: Mode 4 (rising), mode 5 (falling) and mode 6 (either edge) give a one-cycle irqEvent pulse two clocks after the matching pad transition.
- R8: Modes 7 and 0 never raise irqEvent, whatever the pad does.
- R9: Bits 18:16 appear on the pin's irqGroup slice.
- R10: Once bit 21 is written as 1, later writes to that word are ignored until reset.
- R11: Pull (bits 8:7), drive strengths (bits 11:10 and 23:22), Schmitt (bit 15) and input enable (bit 9) appear on the matching pad outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busAddr | input | ADDR_W | Byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, registered |
| busRdValid | output | 1 | Read data valid |
| padIn | input | NUM_PINS | Raw pad input levels |
| padOut | output | NUM_PINS | Pad output value |
| padOe | output | NUM_PINS | Pad output enable |
| periphOut | input | NUM_PINS*3 | Peripheral output per pin and function |
| periphOe | input | NUM_PINS*3 | Peripheral enable per pin and function |
| padPull | output | NUM_PINS*2 | Pull setting per pin |
| padDrive0 | output | NUM_PINS*2 | First drive-strength field |
| padDrive1 | output | NUM_PINS*2 | Second drive-strength field |
| padSchmitt | output | NUM_PINS | Schmitt enable |
| padInEn | output | NUM_PINS | Input enable |
| irqEvent | output | NUM_PINS | Per-pin interrupt event |
| irqGroup | output | NUM_PINS*3 | Interrupt group per pin |

## Verification
The bench goes after edge pulses that fire on the wrong cycle or last more than one cycle. A design with one synchronizer stage too few, or with a stale previous sample, would move or stretch the pulse.

It checks the data-bit read-back in both the output and non-output modes. A design that always returned the stored bit would hide the live pad level.

It writes to a locked word, and a design that let those writes through would change the drive. It also covers the masked modes 0 and 7 and the routing of a peripheral function to the pad. Either would leak an event or a stray output enable if the mode or function decode were off by one.

// File: rtl/gpio_cell_pkg.sv
package gpio_cell_pkg;
  localparam int PIN_IDX_MAX_W = 8;

  typedef enum logic [2:0] {
    M_NONE   = 3'd0,
    M_OUT    = 3'd1,
    M_LVL_HI = 3'd2,
    M_LVL_LO = 3'd3,
    M_RISE   = 3'd4,
    M_FALL   = 3'd5,
    M_BOTH   = 3'd6,
    M_OFF    = 3'd7
  } pin_mode_e;

  // strobes from bus control to the datapath
  typedef struct packed {
    logic                     wrGo;
    logic                     rdGo;
    logic                     hit;
    logic [PIN_IDX_MAX_W-1:0] pinIdx;
  } gpio_strobe_t;

  // bits that hold state; everything else reads zero
  localparam logic [31:0] WORD_KEEP_MASK = 32'h00E7_8FFF;
  localparam int BIT_LOCK = 21;
endpackage

// File: rtl/gpio_cell_ctrl.sv
module gpio_cell_ctrl
  import gpio_cell_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int ADDR_W   = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         busWrEn,
  input  logic         busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output gpio_strobe_t stb,
  output logic         rdValid
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] pinIdxFull;
  logic             inRange;
  logic             unusedLowAddr;

  assign pinIdxFull    = busAddr[ADDR_W-1:2];
  assign unusedLowAddr = ^busAddr[1:0];
  assign inRange       = (int'(pinIdxFull) < NUM_PINS);

  always_comb begin
    stb        = '0;
    stb.wrGo   = busWrEn & inRange;
    stb.rdGo   = busRdEn;
    stb.hit    = inRange;
    stb.pinIdx = PIN_IDX_MAX_W'(pinIdxFull);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= busRdEn;
  end

  // R2: read data is valid exactly one cycle after the request
  p_rd_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> rdValid);
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_cell_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrGo,
  input  logic [31:0] wrData,
  input  logic        padIn,
  input  logic [2:0]  periphOut,
  input  logic [2:0]  periphOe,
  output logic [31:0] readWord,
  output logic [31:0] cfgWord,
  output logic        padOut,
  output logic        padOe,
  output logic        irqEvent
);
  logic [31:0] wordQ;
  logic        syncA, syncB, prevQ;
  pin_mode_e   modeQ;
  logic [1:0]  funcSel;
  logic        locked;

  assign modeQ   = pin_mode_e'(wordQ[3:1]);
  assign funcSel = wordQ[6:5];
  assign locked  = wordQ[BIT_LOCK];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                wordQ <= '0;
    else if (wrGo && !locked) wordQ <= wrData & WORD_KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      prevQ <= 1'b0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  always_comb begin
    unique case (modeQ)
      M_LVL_HI: irqEvent = syncB;
      M_LVL_LO: irqEvent = ~syncB;
      M_RISE:   irqEvent = syncB & ~prevQ;
      M_FALL:   irqEvent = ~syncB & prevQ;
      M_BOTH:   irqEvent = syncB ^ prevQ;
      default:  irqEvent = 1'b0;
    endcase
  end

  always_comb begin
    if (funcSel == 2'd0) begin
      padOut = wordQ[0];
      padOe  = (modeQ == M_OUT);
    end else begin
      padOut = periphOut[funcSel - 2'd1];
      padOe  = periphOe[funcSel - 2'd1];
    end
  end

  assign readWord = {wordQ[31:1], (modeQ == M_OUT) ? wordQ[0] : syncB};
  assign cfgWord  = wordQ;

  // R10: a locked word never changes
  p_lock_freeze_r10: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> $stable(wordQ));
  // R7: a rising-edge event lasts one cycle while the mode is held
  p_rise_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == M_RISE && irqEvent && !wrGo) |=> !irqEvent);
  // R4: an accepted output-mode GPIO write drives the pad next cycle
  p_out_drive_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrGo && !locked && wrData[3:1] == 3'd1 && wrData[6:5] == 2'd0) |=> padOe);
  // R8: masked modes stay quiet
  p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == M_OFF || modeQ == M_NONE) |-> !irqEvent);
endmodule

// File: rtl/gpio_cell_dp.sv
module gpio_cell_dp
  import gpio_cell_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  gpio_strobe_t          stb,
  input  logic [31:0]           wrData,
  output logic [31:0]           rdData,
  input  logic [NUM_PINS-1:0]   padIn,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padOe,
  input  logic [NUM_PINS*3-1:0] periphOut,
  input  logic [NUM_PINS*3-1:0] periphOe,
  output logic [NUM_PINS*2-1:0] padPull,
  output logic [NUM_PINS*2-1:0] padDrive0,
  output logic [NUM_PINS*2-1:0] padDrive1,
  output logic [NUM_PINS-1:0]   padSchmitt,
  output logic [NUM_PINS-1:0]   padInEn,
  output logic [NUM_PINS-1:0]   irqEvent,
  output logic [NUM_PINS*3-1:0] irqGroup
);
  logic [31:0] readWords [NUM_PINS];
  logic [31:0] cfgWords  [NUM_PINS];
  logic [31:0] selWord;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic pinWr;
    assign pinWr = stb.wrGo && (stb.pinIdx == PIN_IDX_MAX_W'(i));

    gpio_pin_slice u_slice (
      .clk       (clk),
      .rstN      (rstN),
      .wrGo      (pinWr),
      .wrData    (wrData),
      .padIn     (padIn[i]),
      .periphOut (periphOut[i*3 +: 3]),
      .periphOe  (periphOe[i*3 +: 3]),
      .readWord  (readWords[i]),
      .cfgWord   (cfgWords[i]),
      .padOut    (padOut[i]),
      .padOe     (padOe[i]),
      .irqEvent  (irqEvent[i])
    );

    assign padPull[i*2 +: 2]   = cfgWords[i][8:7];
    assign padDrive0[i*2 +: 2] = cfgWords[i][11:10];
    assign padDrive1[i*2 +: 2] = cfgWords[i][23:22];
    assign padSchmitt[i]       = cfgWords[i][15];
    assign padInEn[i]          = cfgWords[i][9];
    assign irqGroup[i*3 +: 3]  = cfgWords[i][18:16];
  end

  always_comb begin
    selWord = '0;
    for (int i = 0; i < NUM_PINS; i++)
      if (stb.hit && stb.pinIdx == PIN_IDX_MAX_W'(i)) selWord = readWords[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rdData <= '0;
    else if (stb.rdGo) rdData <= selWord;
  end
endmodule

// File: rtl/gpio_cell_bank.sv
module gpio_cell_bank
  import gpio_cell_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int ADDR_W   = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWrEn,
  input  logic                  busRdEn,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [31:0]           busWrData,
  output logic [31:0]           busRdData,
  output logic                  busRdValid,
  input  logic [NUM_PINS-1:0]   padIn,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padOe,
  input  logic [NUM_PINS*3-1:0] periphOut,
  input  logic [NUM_PINS*3-1:0] periphOe,
  output logic [NUM_PINS*2-1:0] padPull,
  output logic [NUM_PINS*2-1:0] padDrive0,
  output logic [NUM_PINS*2-1:0] padDrive1,
  output logic [NUM_PINS-1:0]   padSchmitt,
  output logic [NUM_PINS-1:0]   padInEn,
  output logic [NUM_PINS-1:0]   irqEvent,
  output logic [NUM_PINS*3-1:0] irqGroup
);
  gpio_strobe_t stb;

  gpio_cell_ctrl #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .stb     (stb),
    .rdValid (busRdValid)
  );

  gpio_cell_dp #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (busWrData),
    .rdData     (busRdData),
    .padIn      (padIn),
    .padOut     (padOut),
    .padOe      (padOe),
    .periphOut  (periphOut),
    .periphOe   (periphOe),
    .padPull    (padPull),
    .padDrive0  (padDrive0),
    .padDrive1  (padDrive1),
    .padSchmitt (padSchmitt),
    .padInEn    (padInEn),
    .irqEvent   (irqEvent),
    .irqGroup   (irqGroup)
  );
endmodule

// File: tb/gpio_cell_bank_test.sv
module gpio_cell_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic busRdValid;
  logic [NP-1:0] padIn = '0, padOut, padOe, padSchmitt, padInEn, irqEvent;
  logic [NP*3-1:0] periphOut = '0, periphOe = '0, irqGroup;
  logic [NP*2-1:0] padPull, padDrive0, padDrive1;

  int nRun = 0, nFail = 0;
  logic [31:0] expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_cell_bank #(.NUM_PINS(NP), .ADDR_W(8)) uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare read results against the scoreboard
  always @(negedge clk) begin
    if (busRdValid) begin
      if (expQ.size() == 0) chk("R2 unexpected read", 32'h1, 32'h0);
      else chk(tagQ.pop_front(), busRdData, expQ.pop_front());
    end
  end

  task automatic wr(int pin, logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 8'(pin*4); busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(int pin, logic [31:0] exp, string tag);
    @(negedge clk);
    expQ.push_back(exp); tagQ.push_back(tag);
    busRdEn = 1'b1; busAddr = 8'(pin*4);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic waitN(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // drive pad at a negedge, then sample at the pulse cycle and one after
  task automatic edgeCheck(logic lvl, logic expPulse, string tag);
    @(negedge clk); padIn[3] = lvl;
    waitN(2);
    chk(tag, 32'(irqEvent[3]), 32'(expPulse));
    waitN(1);
    chk(tag, 32'(irqEvent[3]), 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    nFail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    waitN(2);
    rstN = 1'b1;
    waitN(1);
    // R1 reset state
    chk("R1 padOe", 32'(padOe), 32'h0);
    chk("R1 irqEvent", 32'(irqEvent), 32'h0);
    chk("R1 rdValid", 32'(busRdValid), 32'h0);
    rd(0, 32'h0, "R1 reset word");

    // R2 / R11 / R9: all bits written, unused dropped, lock bit kept clear
    wr(1, 32'hFFDF_FFFF);
    rd(1, 32'h00C7_8FFE, "R2 masked readback");
    chk("R11 pull", 32'(padPull[3:2]), 32'h3);
    chk("R11 drive0", 32'(padDrive0[3:2]), 32'h3);
    chk("R11 drive1", 32'(padDrive1[3:2]), 32'h3);
    chk("R11 schmitt", 32'(padSchmitt[1]), 32'h1);
    chk("R11 inEn", 32'(padInEn[1]), 32'h1);
    chk("R9 group7", 32'(irqGroup[5:3]), 32'h7);
    rd(16, 32'h0, "R2 out of range");

    // R4 / R3 output mode
    wr(0, 32'h3);
    chk("R4 oe", 32'(padOe[0]), 32'h1);
    chk("R4 out", 32'(padOut[0]), 32'h1);
    padIn[0] = 1'b0;
    waitN(3);
    rd(0, 32'h3, "R3 stored bit in output mode");
    wr(0, 32'h2);
    chk("R4 out low", 32'(padOut[0]), 32'h0);
    rd(0, 32'h2, "R3 stored zero");

    // R5 peripheral routing: pin2 function 2 uses index 7
    wr(2, 32'h4E);
    periphOut[7] = 1'b1; periphOe[7] = 1'b1;
    #1;
    chk("R5 periph out", 32'(padOut[2]), 32'h1);
    chk("R5 periph oe", 32'(padOe[2]), 32'h1);
    periphOe[7] = 1'b0;
    #1;
    chk("R5 periph oe low", 32'(padOe[2]), 32'h0);
    wr(3, 32'hE);
    chk("R5 gpio input no oe", 32'(padOe[3]), 32'h0);

    // R3 live pad read in masked input mode
    padIn[3] = 1'b1;
    waitN(3);
    rd(3, 32'hF, "R3 live pad high");
    padIn[3] = 1'b0;
    waitN(3);
    rd(3, 32'hE, "R3 live pad low");

    // R6 levels
    wr(3, 32'h4);
    chk("R6 high mode pad low", 32'(irqEvent[3]), 32'h0);
    @(negedge clk); padIn[3] = 1'b1;
    waitN(2);
    chk("R6 high mode pad high", 32'(irqEvent[3]), 32'h1);
    waitN(2);
    chk("R6 high held", 32'(irqEvent[3]), 32'h1);
    padIn[3] = 1'b0;
    waitN(2);
    wr(3, 32'h6);
    chk("R6 low mode", 32'(irqEvent[3]), 32'h1);

    // R7 edges
    wr(3, 32'h8);
    edgeCheck(1'b1, 1'b1, "R7 rise");
    edgeCheck(1'b0, 1'b0, "R7 rise ignores fall");
    wr(3, 32'hA);
    edgeCheck(1'b1, 1'b0, "R7 fall ignores rise");
    edgeCheck(1'b0, 1'b1, "R7 fall");
    wr(3, 32'hC);
    edgeCheck(1'b1, 1'b1, "R7 both rise");
    edgeCheck(1'b0, 1'b1, "R7 both fall");

    // R8 masked modes
    wr(3, 32'hE);
    edgeCheck(1'b1, 1'b0, "R8 mode7 rise");
    edgeCheck(1'b0, 1'b0, "R8 mode7 fall");
    wr(3, 32'h0);
    edgeCheck(1'b1, 1'b0, "R8 mode0 rise");
    chk("R8 mode0 level", 32'(irqEvent[3]), 32'h0);

    // R9 group field
    wr(3, 32'h0005_0004);
    chk("R9 group5", 32'(irqGroup[11:9]), 32'h5);
    chk("R9 event with group", 32'(irqEvent[3]), 32'h1);

    // R10 lock
    wr(0, 32'h0020_0003);
    wr(0, 32'h0);
    rd(0, 32'h0020_0003, "R10 locked word");
    chk("R10 drive kept", 32'(padOe[0]), 32'h1);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    rd(0, 32'h0, "R10 reset clears lock");
    wr(0, 32'h2);
    rd(0, 32'h2, "R10 writable after reset");

    waitN(2);
    chk("R2 scoreboard drained", 32'(expQ.size()), 32'h0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule